// File: doc/BRIEF.md
# Four-Level Nested Interrupt Controller

This block gathers fifteen interrupt request lines, passes each through a short synchroniser, and holds every request in a sticky pending flag until it is serviced. Each source has its own enable bit, all sources sit behind one global enable, and every source carries a two-bit priority level in the range 0 to 3. A combinational arbiter picks the best eligible source. A controller with two states, `ST_IDLE` and `ST_REQ`, then offers that source to the processor only at an instruction boundary.

While the request is raised, the block presents the source index, its level and a vector address. The processor acknowledges the request, which clears the source's pending flag and marks its level as in service. A return-from-interrupt pulse releases the highest in-service level. Together these give nested preemption across four levels.

The state machine has three transitions. `T_TAKE` goes from `ST_IDLE` to `ST_REQ`: a winner exists and `insn_done` is high, and the winner is latched. `T_ACK` goes from `ST_REQ` to `ST_IDLE` on `irq_ack`. `T_HOLD` keeps either state otherwise.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset `irq_req` is 0 and `in_service` is 0. All enable, priority and pending bits are clear, so no request is raised even with `insn_done` high and lines active.
- R2: A one-cycle high pulse on `irq_in[s]` sets pending flag s, which stays set until source s is acknowledged. It is visible to arbitration SYNC_STAGES+1 cycles after the pulse.
- R3: Writing `wr_data` at `wr_addr` 0 works as follows. Bits 6:0 enable sources 0..6 and bit 7 is the global enable. `wr_addr` 1 bits 7:0 enable sources 7..14. A pending source whose enable or the global enable is 0 is never requested, but it remains pending and is requested once enabled.
- R4: The level of source s is {high bit, low bit}. For s in 0..7, the high bit is bit s of address 2 and the low bit is bit s of address 3. For s in 8..14, the high bit is bit s-8 of address 4 and the low bit is bit s-8 of address 5.
- R5: Among eligible sources the highest level wins, and among equal levels the lowest index wins.
- R6: `irq_req` rises only in the cycle after a clock edge at which `insn_done` was 1.
- R7: While `irq_req` is 1, the outputs `irq_src`, `irq_lvl` and `irq_vec` stay stable until `irq_ack`, and `irq_vec` = VEC_BASE + 8*`irq_src`.
- R8: `irq_ack` while `irq_req` is 1 clears that source's pending flag, sets bit `irq_lvl` of `in_service`, and drops `irq_req` the next cycle. `irq_ack` in `ST_IDLE` has no effect.
- R9: A source is eligible only if its level is strictly above the highest set bit of `in_service`, or if `in_service` is 0.
- R10: A `reti` pulse clears the highest set bit of `in_service`. With `in_service` at 0 it does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_in | input | 15 | Interrupt request lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| insn_done | input | 1 | Instruction boundary indication |
| irq_ack | input | 1 | Processor takes the offered interrupt |
| reti | input | 1 | Return-from-interrupt pulse |
| irq_req | output | 1 | Interrupt offered to the processor |
| irq_src | output | 4 | Offered source index |
| irq_lvl | output | 2 | Offered priority level |
| irq_vec | output | 16 | Offered vector address |
| in_service | output | 4 | One bit per level currently in service |

## Verification
The bench programs random enables, levels and request sets, and lets pending flags and nested in-service levels accumulate across rounds. This reaches the following corners:
- Ties at one level. A design that ignored the polling order would offer a higher index than expected.
- Requests at the level already in service. A design with a non-strict compare would preempt a routine of equal level.
- Sources left pending while disabled. A design that dropped or wrongly served these would lose a request or fire a masked source.

Directed cases also check two further points. No request is raised without `insn_done`. A `reti` releases exactly the top level and leaves the lower nested levels in place.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NSRC    = 15;
    localparam int IDX_W   = $clog2(NSRC);
    localparam int NLVL    = 4;
    localparam int LVL_W   = $clog2(NLVL);
    localparam int LO_CNT  = 7;   // sources enabled by register 0
    localparam int HALF    = 8;   // sources per priority register

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_REQ  = 1'b1
    } ctl_state_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int WIDTH  = 15,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d_in;
    end

    for (genvar k = 1; k < STAGES; k++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[k] <= '0;
            else        stage_q[k] <= stage_q[k-1];
        end
    end

    assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [2:0]                 wr_addr,
    input  logic [7:0]                 wr_data,
    output logic [NSRC-1:0]            src_en,
    output logic [NSRC-1:0][LVL_W-1:0] src_lvl
);
    localparam int HI_CNT = NSRC - HALF;

    logic [LO_CNT-1:0] en_lo_q;
    logic              glob_q;
    logic [HALF-1:0]   en_hi_q;
    logic [HALF-1:0]   ph_lo_q, pl_lo_q;
    logic [HI_CNT-1:0] ph_hi_q, pl_hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_lo_q <= '0;
            glob_q  <= 1'b0;
            en_hi_q <= '0;
            ph_lo_q <= '0;
            pl_lo_q <= '0;
            ph_hi_q <= '0;
            pl_hi_q <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                3'd0: begin
                    en_lo_q <= wr_data[LO_CNT-1:0];
                    glob_q  <= wr_data[7];
                end
                3'd1:    en_hi_q <= wr_data;
                3'd2:    ph_lo_q <= wr_data;
                3'd3:    pl_lo_q <= wr_data;
                3'd4:    ph_hi_q <= wr_data[HI_CNT-1:0];
                3'd5:    pl_hi_q <= wr_data[HI_CNT-1:0];
                default: ;
            endcase
        end
    end

    logic [NSRC-1:0] ph_all, pl_all;
    assign ph_all = {ph_hi_q, ph_lo_q};
    assign pl_all = {pl_hi_q, pl_lo_q};
    assign src_en = glob_q ? {en_hi_q, en_lo_q} : '0;

    for (genvar s = 0; s < NSRC; s++) begin : g_lvl
        assign src_lvl[s] = {ph_all[s], pl_all[s]};
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
(
    input  logic [NSRC-1:0]            cand,
    input  logic [NSRC-1:0][LVL_W-1:0] src_lvl,
    input  logic [NLVL-1:0]            in_service,
    output logic                       win_valid,
    output logic [IDX_W-1:0]           win_idx,
    output logic [LVL_W-1:0]           win_lvl
);
    logic             found;
    logic [IDX_W-1:0] best_idx;
    logic [LVL_W-1:0] best_lvl;
    logic             act_any;
    logic [LVL_W-1:0] act_top;

    always_comb begin
        found    = 1'b0;
        best_idx = '0;
        best_lvl = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (cand[i] && (!found || src_lvl[i] > best_lvl)) begin
                found    = 1'b1;
                best_idx = IDX_W'(i);
                best_lvl = src_lvl[i];
            end
        end
    end

    always_comb begin
        act_any = 1'b0;
        act_top = '0;
        for (int l = 0; l < NLVL; l++) begin
            if (in_service[l]) begin
                act_any = 1'b1;
                act_top = LVL_W'(l);
            end
        end
    end

    assign win_valid = found && (!act_any || best_lvl > act_top);
    assign win_idx   = best_idx;
    assign win_lvl   = best_lvl;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irq_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter int         VEC_W       = 16,
    parameter logic [15:0] VEC_BASE   = 16'h0003
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NSRC-1:0]        irq_in,
    input  logic                   wr_en,
    input  logic [2:0]             wr_addr,
    input  logic [7:0]             wr_data,
    input  logic                   insn_done,
    input  logic                   irq_ack,
    input  logic                   reti,
    output logic                   irq_req,
    output logic [IDX_W-1:0]       irq_src,
    output logic [LVL_W-1:0]       irq_lvl,
    output logic [VEC_W-1:0]       irq_vec,
    output logic [NLVL-1:0]        in_service
);
    logic [NSRC-1:0]            req_sync;
    logic [NSRC-1:0]            pend_q;
    logic [NSRC-1:0]            src_en;
    logic [NSRC-1:0][LVL_W-1:0] src_lvl;
    logic                       win_valid;
    logic [IDX_W-1:0]           win_idx;
    logic [LVL_W-1:0]           win_lvl;
    logic [IDX_W-1:0]           sel_idx_q;
    logic [LVL_W-1:0]           sel_lvl_q;
    logic [NLVL-1:0]            ism_q;
    ctl_state_t                 state_q, state_d;
    logic                       take, ack_ok;

    irq_sync #(.WIDTH(NSRC), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .d_in(irq_in), .d_out(req_sync)
    );

    irq_cfg_regs cfg_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .src_en(src_en), .src_lvl(src_lvl)
    );

    irq_arbiter arb_i (
        .cand(pend_q & src_en), .src_lvl(src_lvl), .in_service(ism_q),
        .win_valid(win_valid), .win_idx(win_idx), .win_lvl(win_lvl)
    );

    // next-state logic: T_TAKE, T_ACK, T_HOLD
    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        ack_ok  = 1'b0;
        unique case (state_q)
            ST_IDLE: if (win_valid && insn_done) begin
                state_d = ST_REQ;
                take    = 1'b1;
            end
            ST_REQ: if (irq_ack) begin
                state_d = ST_IDLE;
                ack_ok  = 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_idx_q <= '0;
            sel_lvl_q <= '0;
        end else if (take) begin
            sel_idx_q <= win_idx;
            sel_lvl_q <= win_lvl;
        end
    end

    // pending flags: new requests win over the acknowledge clear
    logic [NSRC-1:0] pend_clr;
    always_comb begin
        pend_clr = '0;
        if (ack_ok) pend_clr[sel_idx_q] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~pend_clr) | req_sync;
    end

    // in-service tracking
    logic [NLVL-1:0] ism_drop, ism_add;
    always_comb begin
        ism_drop = '0;
        ism_add  = '0;
        if (reti) begin
            for (int l = 0; l < NLVL; l++)
                if (ism_q[l]) ism_drop = NLVL'(1) << l;
        end
        if (ack_ok) ism_add[sel_lvl_q] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ism_q <= '0;
        else        ism_q <= (ism_q & ~ism_drop) | ism_add;
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_REQ:  irq_req = 1'b1;
            default: irq_req = 1'b0;
        endcase
        irq_src    = sel_idx_q;
        irq_lvl    = sel_lvl_q;
        irq_vec    = VEC_BASE[VEC_W-1:0] + (VEC_W'(sel_idx_q) << 3);
        in_service = ism_q;
    end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk
    import irq_pkg::*;
#(
    parameter int          VEC_W    = 16,
    parameter logic [15:0] VEC_BASE = 16'h0003
) (
    input logic             clk,
    input logic             rst_n,
    input logic             insn_done,
    input logic             irq_ack,
    input logic             reti,
    input logic             irq_req,
    input logic [IDX_W-1:0] irq_src,
    input logic [LVL_W-1:0] irq_lvl,
    input logic [VEC_W-1:0] irq_vec,
    input logic [NLVL-1:0]  in_service
);
    function automatic logic [LVL_W-1:0] top_of(input logic [NLVL-1:0] m);
        logic [LVL_W-1:0] t;
        t = '0;
        for (int l = 0; l < NLVL; l++) if (m[l]) t = LVL_W'(l);
        return t;
    endfunction

    // R6
    req_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> $past(insn_done));

    // R7
    req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req && !irq_ack |=> irq_req && $stable(irq_src) && $stable(irq_lvl) && $stable(irq_vec));

    // R8
    ack_marks_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req && irq_ack |=> !irq_req && in_service[$past(irq_lvl)]);

    // R9
    strict_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (in_service == '0 || irq_lvl > top_of(in_service)));

    // R10
    reti_one_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reti && !(irq_req && irq_ack) && in_service != '0 |=>
            $countones(in_service) == $countones($past(in_service)) - 1);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) chk_i (
    .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .irq_ack(irq_ack),
    .reti(reti), .irq_req(irq_req), .irq_src(irq_src), .irq_lvl(irq_lvl),
    .irq_vec(irq_vec), .in_service(in_service)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb_top;
    localparam int          NS   = 15;
    localparam int          SYNC = 2;
    localparam logic [15:0] BASE = 16'h0003;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] irq_in = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        insn_done = 1'b0, irq_ack = 1'b0, reti = 1'b0;
    logic        irq_req;
    logic [3:0]  irq_src;
    logic [1:0]  irq_lvl;
    logic [15:0] irq_vec;
    logic [3:0]  in_service;

    always #5 clk = ~clk;

    prio_irq_ctrl #(.SYNC_STAGES(SYNC), .VEC_BASE(BASE)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .insn_done(insn_done),
        .irq_ack(irq_ack), .reti(reti), .irq_req(irq_req), .irq_src(irq_src),
        .irq_lvl(irq_lvl), .irq_vec(irq_vec), .in_service(in_service)
    );

    int n_chk = 0, n_fail = 0;
    logic [7:0]  m_reg [6];
    logic [14:0] m_pend = '0;
    logic [3:0]  m_ism = '0;

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = d; m_reg[a] = d;
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [14:0] m);
        irq_in = m; tick(1); irq_in = '0;
        m_pend |= m;
        tick(SYNC + 1);
    endtask

    function automatic logic [1:0] lvl_of(input int s);
        if (s < 8) return {m_reg[2][s], m_reg[3][s]};
        return {m_reg[4][s-8], m_reg[5][s-8]};
    endfunction

    function automatic logic en_of(input int s);
        if (!m_reg[0][7]) return 1'b0;
        if (s < 7) return m_reg[0][s];
        return m_reg[1][s-7];
    endfunction

    function automatic int top_lvl(input logic [3:0] m);
        int t = -1;
        for (int l = 0; l < 4; l++) if (m[l]) t = l;
        return t;
    endfunction

    // returns -1 when nothing eligible, else index; lvl via ref
    function automatic int pick(output logic [1:0] lv);
        int b = -1;
        lv = '0;
        for (int s = 0; s < NS; s++)
            if (m_pend[s] && en_of(s) && (b < 0 || lvl_of(s) > lv)) begin
                b = s; lv = lvl_of(s);
            end
        if (b >= 0 && int'(lv) <= top_lvl(m_ism)) b = -1;
        return b;
    endfunction

    // offer at a boundary, check the choice, and acknowledge it
    task automatic serve(input string tag);
        logic [1:0] el;
        int ei;
        ei = pick(el);
        insn_done = 1'b1; tick(1); insn_done = 1'b0;
        check(irq_req == (ei >= 0), {tag, " R5 R9 req"}, irq_req, ei >= 0);
        if (ei >= 0) begin
            check(irq_src == 4'(ei), {tag, " R5 src"}, irq_src, ei);
            check(irq_lvl == el, {tag, " R4 lvl"}, irq_lvl, el);
            check(irq_vec == BASE + 16'(ei * 8), {tag, " R7 vec"}, irq_vec, BASE + ei * 8);
            tick(2);
            check(irq_req && irq_src == 4'(ei), {tag, " R7 held"}, irq_src, ei);
            irq_ack = 1'b1; tick(1); irq_ack = 1'b0;
            m_pend[ei] = 1'b0;
            m_ism[el] = 1'b1;
            check(!irq_req && in_service == m_ism, {tag, " R8 ack"}, in_service, m_ism);
        end
    endtask

    task automatic do_reti(input string tag);
        int t = top_lvl(m_ism);
        reti = 1'b1; tick(1); reti = 1'b0;
        if (t >= 0) m_ism[t] = 1'b0;
        check(in_service == m_ism, {tag, " R10 reti"}, in_service, m_ism);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        int unused;
        for (int a = 0; a < 6; a++) m_reg[a] = '0;
        unused = $urandom(32'd4711);
        tick(3);
        // R1: reset state, lines active, boundary high
        check(irq_req == 0 && in_service == 0, "R1 reset outputs", {irq_req, in_service}, 0);
        rst_n = 1'b1;
        tick(1);
        irq_in = '1; insn_done = 1'b1; tick(5);
        irq_in = '0; insn_done = 1'b0;
        check(irq_req == 0, "R1 nothing enabled", irq_req, 0);
        m_pend = '1;
        // clear leftovers: enable all at level 0 and serve/retire each
        wr(0, 8'hFF); wr(1, 8'hFF);
        for (int k = 0; k < NS; k++) begin serve("R2 drain"); do_reti("R2 drain"); end
        check(m_pend == 0, "R2 drained model", m_pend, 0);

        // R6: no boundary, no request
        pulse(15'h0010);
        tick(4);
        check(irq_req == 0, "R6 no boundary", irq_req, 0);
        // R8: ack in idle ignored
        irq_ack = 1'b1; tick(1); irq_ack = 1'b0;
        check(in_service == 0, "R8 idle ack ignored", in_service, 0);
        serve("R6 boundary");
        do_reti("R10");

        // R3: global off keeps pending
        wr(0, 8'h7F);
        pulse(15'h0002);
        serve("R3 global off");
        check(irq_req == 0, "R3 masked", irq_req, 0);
        wr(0, 8'hFF);
        serve("R3 reenabled");
        do_reti("R3");

        // R4/R9: nested preemption
        wr(2, 8'h01); wr(3, 8'h00);  // src0 level 2
        wr(4, 8'h40); wr(5, 8'h40);  // src14 level 3
        pulse(15'h0001); serve("R9 l2");
        pulse(15'h0020); serve("R9 equal-lower wait");   // src5 level 0 waits
        pulse(15'h4000); serve("R9 l3 preempt");
        check(in_service == 4'b1100, "R9 nested mask", in_service, 4'b1100);
        do_reti("R10 top"); do_reti("R10 next");
        serve("R9 src5 after"); do_reti("R10 last"); do_reti("R10 empty");

        // random rounds
        for (int it = 0; it < 300; it++) begin
            for (int a = 0; a < 6; a++) begin
                logic [7:0] d = 8'($urandom);
                if (a == 0 && ($urandom % 4) != 0) d[7] = 1'b1;
                wr(a, d);
            end
            pulse(15'($urandom) & 15'($urandom));
            serve("rand");
            if ($urandom % 2 == 0 || m_ism == 4'hF) do_reti("rand");
        end
        tick(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule